// File: doc/BRIEF.md
# Two-Digit Multiplexed Display Scanner

This block lights two display digits in turn over one shared segment bus. Each digit has its own active-low enable. A slow pacing strobe (`tick`) drives a fixed six-phase schedule: light digit 0, hold it, light digit 1, hold it, blank both, and hold the blank. The schedule then repeats. Digit 0 shows the most recent command byte and digit 1 shows the most recent data byte.

Values are taken from the live inputs. A digit's value is sampled on the tick that lights it and then held on the bus until the other digit takes over. The bus keeps that value through the blank interval. A separate divider makes the tick. Turning values into segment patterns is done elsewhere.

Top module: `dual_digit_scanner`

## Requirements
- R1: After reset, and again after a reset in the middle of the schedule, both enables are high, the segment bus is 0x00 and the next tick starts a new cycle at the digit 0 phase.
- R2: Without a tick, the segment bus and both enables never change, whatever the value inputs do.
- R3: The first tick of a cycle drives `cmd_byte`, as sampled on that tick, onto the bus. It pulls `dig0_en_n` low and leaves `dig1_en_n` high.
- R4: Digit 0 stays lit for exactly 17 ticks: the lighting tick plus a hold of ON_TICKS (16) ticks.
- R5: On the 18th tick of a cycle, `dig0_en_n` rises, `dig1_en_n` falls, and `dat_byte` as sampled on that tick appears on the bus. Digit 1 is then lit for 17 ticks.
- R6: On the 35th tick both enables go high. They stay high through the 67th tick, a blank hold of OFF_TICKS (32) ticks. The bus keeps the digit 1 value during the blank.
- R7: One full cycle is 67 ticks. The 68th tick lights digit 0 again with the then-current `cmd_byte`.
- R8: A change of `cmd_byte` or `dat_byte` while a digit is held has no effect on the bus until the tick that next lights that digit.
- R9: The two enables are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pacing strobe |
| cmd_byte | input | 8 | Latest command byte, shown on digit 0 |
| dat_byte | input | 8 | Latest data byte, shown on digit 1 |
| seg_bus | output | 8 | Shared segment bus |
| dig0_en_n | output | 1 | Digit 0 enable, active low |
| dig1_en_n | output | 1 | Digit 1 enable, active low |

## Verification
The following are checked on every cycle by the assertions: the enables never overlap, and nothing moves without a tick. A newly lit digit carries the input sampled on its lighting tick, and the hold counter never wraps below zero. The slot lengths of 17, 17 and 33 ticks, and the repeat at the 68th tick, only show up across long tick sequences. The stimulus table walks those sequences. Directed scenarios cover changing inputs mid-hold and a reset in the middle of the schedule.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [2:0] {
    PH_SHOW0 = 3'd0,
    PH_HOLD0 = 3'd1,
    PH_SHOW1 = 3'd2,
    PH_HOLD1 = 3'd3,
    PH_BLANK = 3'd4,
    PH_WAIT  = 3'd5
  } phase_e;
endpackage

// File: rtl/scan_phase_ctrl.sv
module scan_phase_ctrl
  import dds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  output logic load_on,
  output logic load_off,
  output logic count_en,
  output logic light0,
  output logic light1,
  output logic blank,
  output logic bad_phase
);
  phase_e phase_q, phase_d;

  // next-state
  always_comb begin
    phase_d   = phase_q;
    bad_phase = 1'b0;
    case (phase_q)
      PH_SHOW0: if (tick)   phase_d = PH_HOLD0;
      PH_HOLD0: if (expire) phase_d = PH_SHOW1;
      PH_SHOW1: if (tick)   phase_d = PH_HOLD1;
      PH_HOLD1: if (expire) phase_d = PH_BLANK;
      PH_BLANK: if (tick)   phase_d = PH_WAIT;
      PH_WAIT:  if (expire) phase_d = PH_SHOW0;
      default: begin
        phase_d   = PH_SHOW0;
        bad_phase = 1'b1;
      end
    endcase
  end

  // action decode, qualified by the pacing strobe
  always_comb begin
    light0   = tick && (phase_q == PH_SHOW0);
    light1   = tick && (phase_q == PH_SHOW1);
    blank    = tick && (phase_q == PH_BLANK);
    load_on  = light0 || light1;
    load_off = blank;
    count_en = tick && ((phase_q == PH_HOLD0) || (phase_q == PH_HOLD1) ||
                        (phase_q == PH_WAIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_SHOW0;
    else        phase_q <= phase_d;
  end

  // R2: a legal phase only moves on a tick
  p_phase_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bad_phase) |=> $stable(phase_q));

  // R4: holding phases only leave after the counter expires
  p_hold_exit_on_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD0 && !expire) |=> (phase_q == PH_HOLD0));
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int ON_TICKS  = 16,
  parameter int OFF_TICKS = 32,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load_on,
  input  logic load_off,
  input  logic count_en,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)         cnt_d = '0;
    else if (load_on)  cnt_d = CNT_W'(ON_TICKS);
    else if (load_off) cnt_d = CNT_W'(OFF_TICKS);
    else if (count_en) cnt_d = cnt_q - 1'b1;
  end

  assign expire = count_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the on-time load takes the configured value
  p_load_on_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_on && !clear) |=> (cnt_q == CNT_W'(ON_TICKS)));

  // R6: the blank load takes the configured value
  p_load_off_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_off && !clear) |=> (cnt_q == CNT_W'(OFF_TICKS)));

  // R4: a hold never counts below zero
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (cnt_q != '0));
endmodule

// File: rtl/scan_digit_drv.sv
module scan_digit_drv #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             light0,
  input  logic             light1,
  input  logic             blank,
  input  logic [SEG_W-1:0] val0,
  input  logic [SEG_W-1:0] val1,
  output logic [SEG_W-1:0] seg_bus,
  output logic             dig0_en_n,
  output logic             dig1_en_n
);
  logic [SEG_W-1:0] seg_d;
  logic             en0_d, en1_d;

  always_comb begin
    seg_d = seg_bus;
    en0_d = dig0_en_n;
    en1_d = dig1_en_n;
    if (clear) begin
      en0_d = 1'b1;
      en1_d = 1'b1;
      seg_d = '0;
    end else if (light0) begin
      seg_d = val0;
      en0_d = 1'b0;
    end else if (light1) begin
      seg_d = val1;
      en0_d = 1'b1;
      en1_d = 1'b0;
    end else if (blank) begin
      en1_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_bus   <= '0;
      dig0_en_n <= 1'b1;
      dig1_en_n <= 1'b1;
    end else begin
      seg_bus   <= seg_d;
      dig0_en_n <= en0_d;
      dig1_en_n <= en1_d;
    end
  end

  // R9: never two digits lit at once
  p_one_digit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dig0_en_n && !dig1_en_n));

  // R5: digit 1 takes over directly from digit 0
  p_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dig1_en_n) |-> ($past(dig0_en_n) == 1'b0 && dig0_en_n));
endmodule

// File: rtl/dual_digit_scanner.sv
module dual_digit_scanner #(
  parameter int SEG_W     = 8,
  parameter int ON_TICKS  = 16,
  parameter int OFF_TICKS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEG_W-1:0] cmd_byte,
  input  logic [SEG_W-1:0] dat_byte,
  output logic [SEG_W-1:0] seg_bus,
  output logic             dig0_en_n,
  output logic             dig1_en_n
);
  localparam int MAX_TICKS = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic load_on, load_off, count_en, expire;
  logic light0, light1, blank, bad_phase;

  scan_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .expire    (expire),
    .load_on   (load_on),
    .load_off  (load_off),
    .count_en  (count_en),
    .light0    (light0),
    .light1    (light1),
    .blank     (blank),
    .bad_phase (bad_phase)
  );

  scan_timer #(
    .ON_TICKS  (ON_TICKS),
    .OFF_TICKS (OFF_TICKS),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (bad_phase),
    .load_on  (load_on),
    .load_off (load_off),
    .count_en (count_en),
    .expire   (expire)
  );

  scan_digit_drv #(
    .SEG_W (SEG_W)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (bad_phase),
    .light0    (light0),
    .light1    (light1),
    .blank     (blank),
    .val0      (cmd_byte),
    .val1      (dat_byte),
    .seg_bus   (seg_bus),
    .dig0_en_n (dig0_en_n),
    .dig1_en_n (dig1_en_n)
  );

  // R2: outputs are frozen between ticks
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bad_phase) |=> ($stable(seg_bus) && $stable(dig0_en_n) && $stable(dig1_en_n)));

  // R3: digit 0 lights with the command byte of its lighting tick
  p_seg_from_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dig0_en_n) |-> (seg_bus == $past(cmd_byte)));

  // R6: blanking leaves digit 0 dark
  p_blank_both_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dig1_en_n) |-> dig0_en_n);
endmodule

// File: tb/dual_digit_scanner_test.sv
module dual_digit_scanner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] dat_byte = 8'h00;
  logic [7:0] seg_bus;
  logic       dig0_en_n, dig1_en_n;

  int total = 0;
  int bad = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_digit_scanner uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_byte(cmd_byte), .dat_byte(dat_byte),
    .seg_bus(seg_bus), .dig0_en_n(dig0_en_n), .dig1_en_n(dig1_en_n)
  );

  // fields: ticks, cmd, dat, exp seg, exp en0_n, exp en1_n, requirement number
  localparam int NV = 7;
  localparam logic [41:0] VEC [NV] = '{
    {8'd1,  8'hA5, 8'h3C, 8'hA5, 1'b0, 1'b1, 8'd3}, // R3: tick 1
    {8'd16, 8'h11, 8'h3C, 8'hA5, 1'b0, 1'b1, 8'd4}, // R4: tick 17, R8 cmd changed
    {8'd1,  8'h11, 8'hC3, 8'hC3, 1'b1, 1'b0, 8'd5}, // R5: tick 18
    {8'd16, 8'h22, 8'h77, 8'hC3, 1'b1, 1'b0, 8'd8}, // R8: tick 34
    {8'd1,  8'h22, 8'h77, 8'hC3, 1'b1, 1'b1, 8'd6}, // R6: tick 35
    {8'd32, 8'h5A, 8'h99, 8'hC3, 1'b1, 1'b1, 8'd6}, // R6: tick 67
    {8'd1,  8'h5A, 8'h99, 8'h5A, 1'b0, 1'b1, 8'd7}  // R7: tick 68
  };

  task automatic check(input int req, input logic [9:0] got, input logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got seg/en=%h expected %h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // R9 monitor
  always @(negedge clk) if (rst_n && !dig0_en_n && !dig1_en_n) overlap++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, {seg_bus, dig0_en_n, dig1_en_n}, {8'h00, 2'b11}); // R1 in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {seg_bus, dig0_en_n, dig1_en_n}, {8'h00, 2'b11}); // R1 after release

    // R2: inputs move, no tick
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) cmd_byte = 8'(i * 13); dat_byte = 8'(i * 7);
    end
    check(2, {seg_bus, dig0_en_n, dig1_en_n}, {8'h00, 2'b11});

    for (int v = 0; v < NV; v++) begin
      cmd_byte = VEC[v][33:26];
      dat_byte = VEC[v][25:18];
      ticks(int'(VEC[v][41:34]));
      check(int'(VEC[v][7:0]), {seg_bus, dig0_en_n, dig1_en_n}, VEC[v][17:8]);
    end

    // R2: digit 0 lit, long idle stretch with changing inputs
    for (int i = 0; i < 30; i++) begin
      @(negedge clk) cmd_byte = 8'hF0 ^ 8'(i); dat_byte = 8'(i);
    end
    check(2, {seg_bus, dig0_en_n, dig1_en_n}, {8'h5A, 2'b01});

    // R5: second cycle digit 1 picks the live data byte
    dat_byte = 8'h0F;
    ticks(17);
    check(5, {seg_bus, dig0_en_n, dig1_en_n}, {8'h0F, 2'b10});

    // R1: reset in the middle of digit 1
    ticks(5);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(1, {seg_bus, dig0_en_n, dig1_en_n}, {8'h00, 2'b11});
    rst_n = 1'b1;
    cmd_byte = 8'h81;
    ticks(1);
    check(1, {seg_bus, dig0_en_n, dig1_en_n}, {8'h81, 2'b01}); // R1 restart at digit 0

    // R4/R7: full cycle timing again after reset
    ticks(16);
    check(4, {seg_bus, dig0_en_n, dig1_en_n}, {8'h81, 2'b01});
    dat_byte = 8'h42;
    ticks(17);
    check(7, {seg_bus, dig0_en_n, dig1_en_n}, {8'h42, 2'b10});
    ticks(1);
    check(6, {seg_bus, dig0_en_n, dig1_en_n}, {8'h42, 2'b11});
    cmd_byte = 8'hE7;
    ticks(32);
    check(6, {seg_bus, dig0_en_n, dig1_en_n}, {8'h42, 2'b11});
    ticks(1);
    check(7, {seg_bus, dig0_en_n, dig1_en_n}, {8'hE7, 2'b01});

    // R9: no overlap seen across the whole run
    check(9, 10'(overlap), 10'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule